// File: doc/BRIEF.md
# Paired-Pin Pass-Through Multiplexer

This block sits between the embedded microcontroller's internal register bus and a set of general-purpose pads arranged in pairs. Each pair has a source pad and a destination pad. When a channel's routing bit is clear, the destination pad is an ordinary general-purpose pin: the microcontroller sets its direction and output level through two registers. When the routing bit is set, the destination pad stops following those registers. It becomes an output that carries the live level of its paired source pad, unchanged and with no clock delay.

The block also resynchronizes every pad input to the system clock. It exposes the resulting levels through a read-only register. It raises a single-cycle event pulse whenever a source pad changes level, in either direction, for use by interrupt or wake logic elsewhere.

Top module: `pinpass_top`

## Requirements
- R1: After reset the routing, direction and output-data registers all hold 0, so every destination pad has its output enable low and drives 0.
- R2: The routing register sits at address 0x7F85. Bit i (0..3) is the read/write routing bit of channel i. Bits 7..4 always read 0, and writes to them are ignored.
- R3: While routing bit i is 0, destination output i equals bit i of the output-data register, and output enable i equals bit i of the direction register (1 = output, 0 = input).
- R4: While routing bit i is 1, destination output i equals source input i in the same cycle, with no inversion and no register in the path.
- R5: While routing bit i is 1, output enable i is 1 whatever the direction register holds.
- R6: Each channel's routing bit affects only its own destination pad.
- R7: The direction register at 0x7F86 and the output-data register at 0x7F87 are read/write in bits 3..0. Their bits 7..4 read 0.
- R8: The level register at 0x7F88 is read-only. Bits 3..0 return the source pad levels and bits 7..4 return the destination pad levels, each after a two-flop synchronizer. Writes to it change nothing.
- R9: A change of level on source pad i, whether rising or falling, gives a one-cycle pulse on event output i. The pulse appears in the cycle that starts at the second rising clock edge after the change, and no other channel pulses.
- R10: Reads from any other address return 0, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Microcontroller register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| src_pad_in | input | 4 | Input levels of the source pads |
| dst_pad_in | input | 4 | Input levels of the destination pads |
| dst_pad_out | output | 4 | Output value for the destination pads |
| dst_pad_oe | output | 4 | Output enable for the destination pads |
| src_edge_evt | output | 4 | Per-source one-cycle change event |

## Verification
The bench builds the block with its default parameters: four pairs, an 8-bit data bus and two synchronizer stages. With four pairs and eight data bits, every reserved bit of the routing register can be probed. Each pair's half of the level register can also be checked against a distinct bit pattern. The two-stage synchronizer fixes the event pulse two edges after a change, so the bench can sample that cycle and the cycles on either side. The checks also cover mixed routing patterns, in which one channel copies its source while its neighbour follows its own registers.

// File: rtl/pinpass_pkg.sv
package pinpass_pkg;
   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_ROUTE = 3'd1,
      SEL_DIR = 3'd2,
      SEL_DOUT = 3'd3,
      SEL_LVL = 3'd4
   } reg_sel_e;

   localparam int unsigned DEF_ADDR_W = 16;
   localparam int unsigned DEF_DATA_W = 8;
   localparam logic [15:0] DEF_ROUTE_ADDR = 16'h7F85;
   localparam logic [15:0] DEF_DIR_ADDR = 16'h7F86;
   localparam logic [15:0] DEF_DOUT_ADDR = 16'h7F87;
   localparam logic [15:0] DEF_LVL_ADDR = 16'h7F88;
endpackage

// File: rtl/pinpass_sync.sv
module pinpass_sync #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/pinpass_edge.sv
module pinpass_edge #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] evt
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_bit
         assign evt[i] = lvl[i] ^ prev_q[i];
      end
   endgenerate
endmodule

// File: rtl/pinpass_route.sv
module pinpass_route #(
   parameter int unsigned NUM_PAIRS = 4
) (
   input  logic [NUM_PAIRS-1:0] route_en,
   input  logic [NUM_PAIRS-1:0] src_lvl,
   input  logic [NUM_PAIRS-1:0] gpio_dout,
   input  logic [NUM_PAIRS-1:0] gpio_dir,
   output logic [NUM_PAIRS-1:0] pad_out,
   output logic [NUM_PAIRS-1:0] pad_oe
);
   genvar i;
   generate
      for (i = 0; i < NUM_PAIRS; i++) begin : g_pair
         always_comb begin
            if (route_en[i]) begin
               pad_out[i] = src_lvl[i];
               pad_oe[i]  = 1'b1;
            end else begin
               pad_out[i] = gpio_dout[i];
               pad_oe[i]  = gpio_dir[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pinpass_regs.sv
module pinpass_regs
   import pinpass_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 4,
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter logic [ADDR_W-1:0] ROUTE_ADDR = ADDR_W'(DEF_ROUTE_ADDR),
   parameter logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DEF_DIR_ADDR),
   parameter logic [ADDR_W-1:0] DOUT_ADDR = ADDR_W'(DEF_DOUT_ADDR),
   parameter logic [ADDR_W-1:0] LVL_ADDR = ADDR_W'(DEF_LVL_ADDR)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_PAIRS-1:0] src_sync,
   input  logic [NUM_PAIRS-1:0] dst_sync,
   output logic [NUM_PAIRS-1:0] route_q,
   output logic [NUM_PAIRS-1:0] dir_q,
   output logic [NUM_PAIRS-1:0] dout_q
);
   reg_sel_e sel;

   always_comb begin
      if (bus_addr == ROUTE_ADDR)     sel = SEL_ROUTE;
      else if (bus_addr == DIR_ADDR)  sel = SEL_DIR;
      else if (bus_addr == DOUT_ADDR) sel = SEL_DOUT;
      else if (bus_addr == LVL_ADDR)  sel = SEL_LVL;
      else                            sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
         dir_q   <= '0;
         dout_q  <= '0;
      end else if (bus_we) begin
         case (sel)
            SEL_ROUTE: route_q <= bus_wdata[NUM_PAIRS-1:0];
            SEL_DIR:   dir_q   <= bus_wdata[NUM_PAIRS-1:0];
            SEL_DOUT:  dout_q  <= bus_wdata[NUM_PAIRS-1:0];
            default:   ;
         endcase
      end
   end

   generate
      if (NUM_PAIRS < DATA_W) begin : g_spare
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PAIRS];
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_ROUTE: bus_rdata[NUM_PAIRS-1:0] = route_q;
         SEL_DIR:   bus_rdata[NUM_PAIRS-1:0] = dir_q;
         SEL_DOUT:  bus_rdata[NUM_PAIRS-1:0] = dout_q;
         SEL_LVL: begin
            bus_rdata[NUM_PAIRS-1:0]           = src_sync;
            bus_rdata[2*NUM_PAIRS-1:NUM_PAIRS] = dst_sync;
         end
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pinpass_top.sv
module pinpass_top
   import pinpass_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 4,
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] ROUTE_ADDR = ADDR_W'(DEF_ROUTE_ADDR),
   parameter logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DEF_DIR_ADDR),
   parameter logic [ADDR_W-1:0] DOUT_ADDR = ADDR_W'(DEF_DOUT_ADDR),
   parameter logic [ADDR_W-1:0] LVL_ADDR = ADDR_W'(DEF_LVL_ADDR)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_PAIRS-1:0] src_pad_in,
   input  logic [NUM_PAIRS-1:0] dst_pad_in,
   output logic [NUM_PAIRS-1:0] dst_pad_out,
   output logic [NUM_PAIRS-1:0] dst_pad_oe,
   output logic [NUM_PAIRS-1:0] src_edge_evt
);
   generate
      if (NUM_PAIRS < 1 || 2 * NUM_PAIRS > DATA_W) begin : g_bad_pairs
         $error("pinpass_top: NUM_PAIRS must be >= 1 and fit twice in DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pinpass_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_PAIRS-1:0] route_bits;
   logic [NUM_PAIRS-1:0] dir_bits;
   logic [NUM_PAIRS-1:0] dout_bits;
   logic [NUM_PAIRS-1:0] src_sync;
   logic [NUM_PAIRS-1:0] dst_sync;

   pinpass_regs #(
      .NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .ROUTE_ADDR(ROUTE_ADDR), .DIR_ADDR(DIR_ADDR),
      .DOUT_ADDR(DOUT_ADDR), .LVL_ADDR(LVL_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_sync(src_sync), .dst_sync(dst_sync),
      .route_q(route_bits), .dir_q(dir_bits), .dout_q(dout_bits)
   );

   pinpass_sync #(.WIDTH(NUM_PAIRS), .STAGES(SYNC_STAGES)) u_src_sync (
      .clk(clk), .rst_n(rst_n), .d_in(src_pad_in), .q_out(src_sync)
   );

   pinpass_sync #(.WIDTH(NUM_PAIRS), .STAGES(SYNC_STAGES)) u_dst_sync (
      .clk(clk), .rst_n(rst_n), .d_in(dst_pad_in), .q_out(dst_sync)
   );

   pinpass_edge #(.WIDTH(NUM_PAIRS)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(src_sync), .evt(src_edge_evt)
   );

   pinpass_route #(.NUM_PAIRS(NUM_PAIRS)) u_route (
      .route_en(route_bits), .src_lvl(src_pad_in),
      .gpio_dout(dout_bits), .gpio_dir(dir_bits),
      .pad_out(dst_pad_out), .pad_oe(dst_pad_oe)
   );
endmodule

// File: rtl/pinpass_chk.sv
module pinpass_chk #(
   parameter int unsigned NUM_PAIRS = 4,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] ROUTE_ADDR = '0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic [NUM_PAIRS-1:0] src_pad_in,
   input logic [NUM_PAIRS-1:0] dst_pad_out,
   input logic [NUM_PAIRS-1:0] dst_pad_oe,
   input logic [NUM_PAIRS-1:0] src_edge_evt,
   input logic [NUM_PAIRS-1:0] route_q,
   input logic [NUM_PAIRS-1:0] dir_q,
   input logic [NUM_PAIRS-1:0] dout_q
);
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R2: reserved bits of the routing register read as zero
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ROUTE_ADDR) |-> (bus_rdata[DATA_W-1:NUM_PAIRS] == '0));

   genvar i;
   generate
      for (i = 0; i < NUM_PAIRS; i++) begin : g_ch
         // R4: routed channel copies its source
         a_r4_copy_src: assert property (@(posedge clk) disable iff (!rst_n)
            route_q[i] |-> (dst_pad_out[i] == src_pad_in[i]));
         // R5: routed channel is always driven
         a_r5_force_oe: assert property (@(posedge clk) disable iff (!rst_n)
            route_q[i] |-> dst_pad_oe[i]);
         // R3: unrouted channel follows its own registers
         a_r3_normal_gpio: assert property (@(posedge clk) disable iff (!rst_n)
            !route_q[i] |-> (dst_pad_oe[i] == dir_q[i] && dst_pad_out[i] == dout_q[i]));
         // R9: event follows a source change by the synchronizer delay
         a_r9_edge_event: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3) |->
               (src_edge_evt[i] == ($past(src_pad_in[i], 2) != $past(src_pad_in[i], 3))));
      end
   endgenerate
endmodule

bind pinpass_top pinpass_chk #(
   .NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROUTE_ADDR(ROUTE_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .src_pad_in(src_pad_in), .dst_pad_out(dst_pad_out), .dst_pad_oe(dst_pad_oe),
   .src_edge_evt(src_edge_evt), .route_q(route_bits), .dir_q(dir_bits),
   .dout_q(dout_bits)
);

// File: tb/sim_pinpass_top.sv
module sim_pinpass_top;
   localparam logic [15:0] A_ROUTE = 16'h7F85;
   localparam logic [15:0] A_DIR = 16'h7F86;
   localparam logic [15:0] A_DOUT = 16'h7F87;
   localparam logic [15:0] A_LVL = 16'h7F88;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [3:0]  src_pad_in = '0;
   logic [3:0]  dst_pad_in = '0;
   logic [3:0]  dst_pad_out;
   logic [3:0]  dst_pad_oe;
   logic [3:0]  src_edge_evt;

   int n_checks = 0;
   int n_fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pinpass_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pad_in(src_pad_in),
      .dst_pad_in(dst_pad_in), .dst_pad_out(dst_pad_out), .dst_pad_oe(dst_pad_oe),
      .src_edge_evt(src_edge_evt)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(A_ROUTE, d); check("R1 route reset", d, 8'h00);
      rd(A_DIR, d);   check("R1 dir reset", d, 8'h00);
      rd(A_DOUT, d);  check("R1 dout reset", d, 8'h00);
      check("R1 oe reset", {4'h0, dst_pad_oe}, 8'h00);
      check("R1 out reset", {4'h0, dst_pad_out}, 8'h00);
   endtask

   task automatic t_route_reg();
      logic [7:0] d;
      wr(A_ROUTE, 8'hFA);
      rd(A_ROUTE, d); check("R2 reserved masked", d, 8'h0A);
      wr(A_ROUTE, 8'h00);
      rd(A_ROUTE, d); check("R2 cleared", d, 8'h00);
   endtask

   task automatic t_dir_dout();
      logic [7:0] d;
      wr(A_DIR, 8'hF6);
      rd(A_DIR, d); check("R7 dir rw", d, 8'h06);
      wr(A_DOUT, 8'h3C);
      rd(A_DOUT, d); check("R7 dout rw", d, 8'h0C);
   endtask

   task automatic t_normal();
      @(negedge clk);
      check("R3 oe follows dir", {4'h0, dst_pad_oe}, 8'h06);
      check("R3 out follows dout", {4'h0, dst_pad_out}, 8'h0C);
      src_pad_in = 4'hF;
      #1 check("R3 src ignored", {4'h0, dst_pad_out}, 8'h0C);
   endtask

   task automatic t_passthru();
      wr(A_ROUTE, 8'h0F);
      @(negedge clk);
      src_pad_in = 4'b0101;
      #1 check("R4 copy 0101", {4'h0, dst_pad_out}, 8'h05);
      check("R5 oe forced", {4'h0, dst_pad_oe}, 8'h0F);
      @(negedge clk);
      src_pad_in = 4'b1010;
      #1 check("R4 copy 1010", {4'h0, dst_pad_out}, 8'h0A);
   endtask

   task automatic t_mixed();
      wr(A_ROUTE, 8'h09);
      @(negedge clk);
      src_pad_in = 4'b0110;
      #1;
      // ch0,3 routed (src 0,0); ch1,2 from dout 0xC bits -> 0,1
      check("R6 mixed out", {4'h0, dst_pad_out}, 8'h04);
      check("R6 mixed oe", {4'h0, dst_pad_oe}, 8'h0F);
      wr(A_DIR, 8'h00);
      @(negedge clk);
      check("R6 mixed oe dir0", {4'h0, dst_pad_oe}, 8'h09);
      wr(A_ROUTE, 8'h00);
   endtask

   task automatic t_levels();
      logic [7:0] d;
      @(negedge clk);
      src_pad_in = 4'b0101; dst_pad_in = 4'b1010;
      @(posedge clk); @(posedge clk);
      rd(A_LVL, d); check("R8 levels", d, 8'hA5);
      wr(A_LVL, 8'h00);
      rd(A_LVL, d); check("R8 write ignored", d, 8'hA5);
   endtask

   task automatic t_edges();
      @(negedge clk);
      src_pad_in = 4'b0000;
      repeat (4) @(negedge clk);
      src_pad_in = 4'b0010;
      @(negedge clk); check("R9 not yet", {4'h0, src_edge_evt}, 8'h00);
      @(negedge clk); check("R9 rise pulse", {4'h0, src_edge_evt}, 8'h02);
      @(negedge clk); check("R9 one cycle", {4'h0, src_edge_evt}, 8'h00);
      src_pad_in = 4'b0000;
      @(negedge clk);
      @(negedge clk); check("R9 fall pulse", {4'h0, src_edge_evt}, 8'h02);
      @(negedge clk); check("R9 fall end", {4'h0, src_edge_evt}, 8'h00);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      wr(16'h7F84, 8'hFF);
      wr(16'h7F89, 8'hFF);
      rd(16'h7F84, d); check("R10 read zero", d, 8'h00);
      rd(A_ROUTE, d);  check("R10 route untouched", d, 8'h00);
      rd(A_DIR, d);    check("R10 dir untouched", d, 8'h00);
      rd(A_DOUT, d);   check("R10 dout untouched", d, 8'h0C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_route_reg();
      t_dir_dout();
      t_normal();
      t_passthru();
      t_mixed();
      t_levels();
      t_edges();
      t_unmapped();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual running expected done");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule